// File: doc/BRIEF.md
# Pin Interrupt Controller Register Bank

This block is the control and status side of a 32-input pin interrupt controller. It watches a vector of external pins, brings each through a two-flop synchronizer and optionally inverts it. It then detects either a high level or a rising edge per input and records each detection in a sticky latch word. Latched events that are also unmasked form the request word. The single interrupt output is high while any request bit is set.

Software reaches the block over a simple 32-bit register bus. Three of its state words, mask, edge select and invert select, have no direct write address. Each is changed through a pair of alias registers: a write to one alias sets the bits written as 1, and a write to the other clears them. Reading either alias returns the shared word.

Every access must be a full word. Wrongly sized, misaligned and unmapped accesses get an error status and change nothing. A per-instance parameter chooses the reset value of the routing (assign) register. The bus has no back-pressure: the block accepts an access in every cycle that `req_valid` is high and answers exactly one cycle later.

Top module: `pin_irq_regbank`

## Requirements
- R1: The register index is `req_addr[5:2]`. Index 0 is mask-set, 1 mask-clear, 2 request, 3 assign, 4 edge-set, 5 edge-clear, 6 invert-set, 7 invert-clear, 8 pin-state and 9 latch.
- R2: A write to a set alias forces to 1 every bit of its word that is written as 1. A write to a clear alias forces those bits to 0. Bits written as 0 keep their value.
- R3: A read of either alias of a pair returns the current value of the shared word.
- R4: The assign register stores a written word and reads it back. Its reset value is 0x00000101 for INST 0 and 2, 0x01010000 for INST 1 and 0x02020303 for INST 3.
- R5: Mask, edge, invert and latch reset to zero, and `irq_o` is low after reset.
- R6: An access whose `req_size` is not 2 (word) returns status 1 with rdata 0 and has no effect. This check wins over the address checks.
- R7: A word access that is misaligned or has an index above 9 returns status 2 with rdata 0 and has no effect. A good access returns status 0.
- R8: Each accepted access produces `rsp_valid` for exactly the following cycle.
- R9: Each input is XORed with its invert bit after synchronization. With edge bit 0, a high level sets the latch bit. With edge bit 1, only a 0-to-1 change sets it, so a held input does not retrigger.
- R10: Writing 1s to the latch register clears those latch bits. A detection in the same cycle wins over the clear.
- R11: The request register reads latch AND mask. `irq_o` is high exactly when that word is non-zero.
- R12: Pin-state reads the synchronized pins XOR invert, two clocks behind the pins. Writes to request and pin-state return status 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPIN | Asynchronous pin inputs |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset from block base |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_status | output | 2 | 0 ok, 1 wrong size, 2 unmapped |
| rsp_rdata | output | DW | Read data, 0 on error or on a write |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong bit in mask, edge or invert shows up at the next read of either alias. It also changes the detection path, and that is visible on `irq_o` three clocks after a pin change. A latch bit that is stuck or cleared when it should not be shows in the next latch or request read and at once on `irq_o` if the bit is unmasked. A decode error shows in the status of the very next response, or as a changed assign value on the following read.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [3:0] {
    RG_MASK_SET = 4'd0,
    RG_MASK_CLR = 4'd1,
    RG_REQ      = 4'd2,
    RG_ASSIGN   = 4'd3,
    RG_EDGE_SET = 4'd4,
    RG_EDGE_CLR = 4'd5,
    RG_INV_SET  = 4'd6,
    RG_INV_CLR  = 4'd7,
    RG_PINS     = 4'd8,
    RG_LATCH    = 4'd9
  } reg_sel_e;

  localparam int NUM_REGS = 10;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_SIZE = 2'd1,
    ST_MAP  = 2'd2
  } rsp_status_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [31:0] route_reset(input int inst);
    case (inst)
      0, 2:    return 32'h0000_0101;
      1:       return 32'h0101_0000;
      3:       return 32'h0202_0303;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/pin_irq_decode.sv
module pin_irq_decode
  import pin_irq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output reg_sel_e      sel,
  output rsp_status_e   status
);
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  logic          misaligned;
  logic          out_of_map;

  assign idx        = addr[AW-1:2];
  assign misaligned = addr[1:0] != 2'b00;
  assign out_of_map = idx > IW'(NUM_REGS - 1);
  assign sel        = reg_sel_e'(idx[3:0]);

  // size is checked before the address
  always_comb begin
    if (size != SZ_WORD)               status = ST_SIZE;
    else if (misaligned || out_of_map) status = ST_MAP;
    else                               status = ST_OK;
  end
endmodule

// File: rtl/pin_irq_alias_word.sv
module pin_irq_alias_word #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_o <= '0;
    else if (set_we) word_o <= word_o | wdata;
    else if (clr_we) word_o <= word_o & ~wdata;
  end

  // R2
  alias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(word_o));
  // R2
  alias_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((word_o & $past(wdata)) == $past(wdata)));
  // R2
  alias_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((word_o & $past(wdata)) == '0));
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] invert_i,
  input  logic [N-1:0] edge_i,
  output logic [N-1:0] view_o,
  output logic [N-1:0] event_o
);
  logic [N-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pins_i;
      sync2_q <= sync1_q;
      prev_q  <= view_o;
    end
  end

  assign view_o = sync2_q ^ invert_i;

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign event_o[b] = edge_i[b] ? (view_o[b] & ~prev_q[b]) : view_o[b];
  end

  // R9
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i[0] && $stable(edge_i[0]) && $stable(view_o[0])) |-> !event_o[0]);
endmodule

// File: rtl/pin_irq_regbank.sv
module pin_irq_regbank
  import pin_irq_pkg::*;
#(
  parameter int INST = 0,
  parameter int DW   = 32,
  parameter int NPIN = DW,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_i,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [1:0]      rsp_status,
  output logic [DW-1:0]   rsp_rdata,
  output logic            irq_o
);
  localparam logic [DW-1:0] ROUTE_RST = DW'(route_reset(INST));

  reg_sel_e    sel;
  rsp_status_e status;
  logic        hit_wr;

  logic [NPIN-1:0] mask_w, edge_w, inv_w, view_w, event_w, latch_q, req_w;
  logic [DW-1:0]   route_q, rd_mux;

  pin_irq_decode #(.AW(AW)) u_dec (
    .addr(req_addr), .size(req_size), .sel(sel), .status(status)
  );

  assign hit_wr = req_valid && req_write && (status == ST_OK);

  pin_irq_alias_word #(.N(NPIN)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_we(hit_wr && sel == RG_MASK_SET), .clr_we(hit_wr && sel == RG_MASK_CLR),
    .wdata(req_wdata[NPIN-1:0]), .word_o(mask_w)
  );
  pin_irq_alias_word #(.N(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .set_we(hit_wr && sel == RG_EDGE_SET), .clr_we(hit_wr && sel == RG_EDGE_CLR),
    .wdata(req_wdata[NPIN-1:0]), .word_o(edge_w)
  );
  pin_irq_alias_word #(.N(NPIN)) u_inv (
    .clk(clk), .rst_n(rst_n),
    .set_we(hit_wr && sel == RG_INV_SET), .clr_we(hit_wr && sel == RG_INV_CLR),
    .wdata(req_wdata[NPIN-1:0]), .word_o(inv_w)
  );

  pin_irq_detect #(.N(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .invert_i(inv_w),
    .edge_i(edge_w), .view_o(view_w), .event_o(event_w)
  );

  logic [NPIN-1:0] latch_clr;
  assign latch_clr = (hit_wr && sel == RG_LATCH) ? req_wdata[NPIN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      route_q <= ROUTE_RST;
    end else begin
      latch_q <= (latch_q & ~latch_clr) | event_w;
      if (hit_wr && sel == RG_ASSIGN) route_q <= req_wdata;
    end
  end

  assign req_w = latch_q & mask_w;
  assign irq_o = |req_w;

  always_comb begin
    case (sel)
      RG_MASK_SET, RG_MASK_CLR: rd_mux = DW'(mask_w);
      RG_EDGE_SET, RG_EDGE_CLR: rd_mux = DW'(edge_w);
      RG_INV_SET,  RG_INV_CLR:  rd_mux = DW'(inv_w);
      RG_REQ:                   rd_mux = DW'(req_w);
      RG_ASSIGN:                rd_mux = route_q;
      RG_PINS:                  rd_mux = DW'(view_w);
      RG_LATCH:                 rd_mux = DW'(latch_q);
      default:                  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_status <= req_valid ? status : ST_OK;
      rsp_rdata  <= (req_valid && !req_write && status == ST_OK) ? rd_mux : '0;
    end
  end

  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R6
  size_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SZ_WORD) |=> (rsp_status == ST_SIZE && rsp_rdata == '0));
  // R7
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && status != ST_OK) |=> $stable(route_q));
  // R10
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_wr && sel == RG_LATCH) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
endmodule

// File: tb/pin_irq_regbank_tb.sv
module pin_irq_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] pins = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_valid3, irq, irq3;
  logic [1:0]    rsp_status, rsp_status3;
  logic [DW-1:0] rsp_rdata, rsp_rdata3;

  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_regbank #(.INST(0), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .irq_o(irq)
  );
  pin_irq_regbank #(.INST(3), .DW(DW), .AW(AW)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .pins_i('0), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid3), .rsp_status(rsp_status3),
    .rsp_rdata(rsp_rdata3), .irq_o(irq3)
  );

  localparam logic [AW-1:0] A_MSET = 8'h00, A_MCLR = 8'h04, A_REQ = 8'h08,
    A_ASG = 8'h0C, A_ESET = 8'h10, A_ECLR = 8'h14, A_ISET = 8'h18,
    A_ICLR = 8'h1C, A_PINS = 8'h20, A_LAT = 8'h24;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [DW-1:0] wd, output logic [DW-1:0] rd, output logic [1:0] st);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    total++;
    if (rsp_valid !== 1'b1) begin
      bad++;
      $display("FAIL R8 got=%b exp=1", rsp_valid);
    end
    rd = rsp_rdata; st = rsp_status;
  endtask

  task automatic wr_ok(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    logic [DW-1:0] rd; logic [1:0] st;
    acc(1'b1, a, 2'd2, wd, rd, st);
    check(tag, DW'(st), 0);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] rd; logic [1:0] st;
    acc(1'b0, a, 2'd2, '0, rd, st);
    check(tag, rd, exp);
  endtask

  task automatic t_reset;
    check("R5 irq after reset", DW'(irq), 0);
    check("R8 idle rsp_valid", DW'(rsp_valid), 0);
    rd_chk(A_ASG, 32'h0000_0101, "R4 assign reset inst0");
    check("R4 assign reset inst3", rsp_rdata3, 32'h0202_0303);
    rd_chk(A_MSET, 0, "R5 mask reset");
    rd_chk(A_EDGE_CHK_ADDR(), 0, "R5 edge reset");
    rd_chk(A_ICLR, 0, "R5 invert reset");
    rd_chk(A_LAT, 0, "R5 latch reset");
  endtask

  function automatic logic [AW-1:0] A_EDGE_CHK_ADDR();
    return A_ECLR;
  endfunction

  task automatic t_alias;
    wr_ok(A_MSET, 32'h0000_00F0, "R2 mask set status");
    rd_chk(A_MCLR, 32'h0000_00F0, "R3 mask via clear alias");
    wr_ok(A_MCLR, 32'h0000_0030, "R2 mask clear status");
    rd_chk(A_MSET, 32'h0000_00C0, "R2 mask after clear");
    wr_ok(A_MSET, 32'h0, "R2 zero write");
    rd_chk(A_MCLR, 32'h0000_00C0, "R2 zero bits unchanged");
    wr_ok(A_ESET, 32'h8000_0000, "R1 edge set");
    rd_chk(A_ECLR, 32'h8000_0000, "R3 edge shared word");
    wr_ok(A_ECLR, 32'h8000_0000, "R1 edge clear");
    rd_chk(A_ESET, 32'h0, "R2 edge cleared");
  endtask

  task automatic t_plain;
    wr_ok(A_ASG, 32'hA5A5_1234, "R4 assign write");
    rd_chk(A_ASG, 32'hA5A5_1234, "R4 assign readback");
    wr_ok(A_REQ, 32'hFFFF_FFFF, "R12 request write accepted");
    rd_chk(A_REQ, 32'h0, "R12 request write ignored");
    wr_ok(A_PINS, 32'hFFFF_FFFF, "R12 pin-state write accepted");
    rd_chk(A_PINS, 32'h0, "R12 pin-state write ignored");
  endtask

  task automatic t_errors;
    logic [DW-1:0] rd; logic [1:0] st;
    acc(1'b1, A_ASG, 2'd1, 32'h0000_FFFF, rd, st);
    check("R6 half write status", DW'(st), 1);
    rd_chk(A_ASG, 32'hA5A5_1234, "R6 half write no effect");
    acc(1'b0, A_ASG, 2'd0, '0, rd, st);
    check("R6 byte read status", DW'(st), 1);
    check("R6 byte read data", rd, 0);
    acc(1'b1, 8'h28, 2'd0, '0, rd, st);
    check("R6 size beats unmapped", DW'(st), 1);
    acc(1'b1, 8'h28, 2'd2, 32'hFFFF_FFFF, rd, st);
    check("R7 unmapped write status", DW'(st), 2);
    acc(1'b0, 8'h28, 2'd2, '0, rd, st);
    check("R7 unmapped read status", DW'(st), 2);
    check("R7 unmapped read data", rd, 0);
    acc(1'b1, 8'h0D, 2'd2, 32'h0, rd, st);
    check("R7 misaligned status", DW'(st), 2);
    rd_chk(A_ASG, 32'hA5A5_1234, "R7 error writes no effect");
  endtask

  task automatic t_invert;
    wr_ok(A_ISET, 32'h0000_0004, "R9 invert set");
    wait_cyc(4);
    rd_chk(A_PINS, 32'h0000_0004, "R12 pin-state inverted");
    rd_chk(A_LAT, 32'h0000_0004, "R9 inverted level latched");
    rd_chk(A_REQ, 32'h0, "R11 unmasked latch no request");
    check("R11 irq low when masked off", DW'(irq), 0);
    wr_ok(A_ICLR, 32'h0000_0004, "R9 invert clear");
    wait_cyc(3);
    wr_ok(A_LAT, 32'h0000_0004, "R10 latch clear");
    rd_chk(A_LAT, 32'h0, "R10 latch cleared");
  endtask

  task automatic t_level;
    wr_ok(A_MSET, 32'h0000_0001, "R11 mask bit0");
    @(negedge clk); pins[0] = 1'b1;
    wait_cyc(1);
    rd_chk(A_PINS, 32'h0000_0001, "R12 pin-state two-clock lag");
    check("R9 level latched irq", DW'(irq), 1);
    rd_chk(A_REQ, 32'h0000_0001, "R11 request reads latch&mask");
    wr_ok(A_LAT, 32'h0000_0001, "R10 clear while level held");
    rd_chk(A_LAT, 32'h0000_0001, "R10 detection wins over clear");
    @(negedge clk); pins[0] = 1'b0;
    wait_cyc(3);
    wr_ok(A_LAT, 32'h0000_0001, "R10 clear after release");
    check("R11 irq drops", DW'(irq), 0);
    rd_chk(A_LAT, 32'h0, "R10 latch empty");
  endtask

  task automatic t_edge;
    wr_ok(A_ESET, 32'h0000_0002, "R9 edge mode bit1");
    wr_ok(A_MSET, 32'h0000_0002, "R11 mask bit1");
    @(negedge clk); pins[1] = 1'b1;
    wait_cyc(4);
    check("R9 rising edge irq", DW'(irq), 1);
    rd_chk(A_LAT, 32'h0000_0002, "R9 rising edge latched");
    wr_ok(A_LAT, 32'h0000_0002, "R10 clear edge latch");
    wait_cyc(3);
    rd_chk(A_LAT, 32'h0, "R9 held input no retrigger");
    check("R11 irq low after edge clear", DW'(irq), 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_alias();
    t_plain();
    t_errors();
    t_invert();
    t_level();
    t_edge();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule